// File: doc/BRIEF.md
# Two-Channel Circular Descriptor DMA Engine

This block moves single data elements between a peripheral's queue registers and system memory on behalf of two peripheral request lines. Each channel owns a descriptor: a current source address, a current destination address, signed per-element offsets for both, an element size, an initial and a current iteration count, and signed end-of-loop adjustments for both addresses. A request on a channel causes exactly one element to be read from the source address and then written to the destination address over a single shared memory port.

Channel 0 is meant to feed a converter's command queue. Its source walks through a command list in memory and its destination stays fixed on the queue's push register. Channel 1 drains a result queue. Its source stays fixed on the pop register and its destination walks through a result buffer in memory. When a channel's iteration count runs out, its end-of-loop adjustments are added to its addresses along with the normal offsets, and its count reloads from the initial value. With an adjustment equal to minus the list length, the walking address returns to the start of its buffer, so each channel cycles through a circular buffer without any modulo hardware.

A descriptor is programmed from the configuration inputs with a one-cycle load strobe for that channel.

Top module: `dma_ring_engine`

## Requirements
- R1: After reset, `mem_req_o` and `ack_o` stay low until a request arrives.
- R2: Each request pulse on a channel produces exactly one read access (`mem_we_o`=0), then exactly one write access (`mem_we_o`=1). One cycle after the write is accepted, that channel's `ack_o` bit pulses for one cycle.
- R3: The read uses the channel's current source address and the write uses its current destination address. `mem_size_o` carries the descriptor size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). The written data equals the read data with the bits above the element size cleared.
- R4: After each element, the source address advances by the signed source offset and the destination address advances by the signed destination offset. A zero offset keeps an address fixed.
- R5: On the element that completes the loop (current count equal to 1), the signed end-of-loop adjustments are also added to both addresses, and the current count reloads from the initial count. A list of N entries with adjustment −N·size therefore restarts at its first entry.
- R6: When both channels are pending in the same cycle and the port is free, channel 0 is served first.
- R7: A request that arrives while a transfer is in progress, including one for the busy channel itself, is held and served after that transfer ends.
- R8: The configuration inputs are copied into a channel's descriptor only in a cycle where that channel's load bit is high. At other times, changes on those inputs have no effect on transfers.
- R9: While `mem_req_o` is high and `mem_ready_i` is low, the access is held with unchanged address, direction and data until it is accepted.
- R10: With an initial count of 1, every element completes the loop. A source offset of +s with adjustment −s therefore reads the same address on every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NCH | Peripheral request pulses, one per channel |
| ack_o | output | NCH | One-cycle completion pulse per channel |
| ld_i | input | NCH | Descriptor load strobe per channel |
| cfg_src_i | input | NCH x AW | Start source address |
| cfg_dst_i | input | NCH x AW | Start destination address |
| cfg_soff_i | input | NCH x AW | Signed source offset per element |
| cfg_doff_i | input | NCH x AW | Signed destination offset per element |
| cfg_slast_i | input | NCH x AW | Signed source end-of-loop adjustment |
| cfg_dlast_i | input | NCH x AW | Signed destination end-of-loop adjustment |
| cfg_size_i | input | NCH x 2 | Element size code |
| cfg_iter_i | input | NCH x CW | Initial iteration count (1..MAX_ITER) |
| mem_req_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid when accepted |
| mem_ready_i | input | 1 | Access accepted this cycle |

## Verification
The hardest cases to reach from the ports are a request for the channel that is already mid-transfer, and an access held across several stalled cycles. The bench raises a second request while the first transfer's read is still outstanding, and it runs a separate scenario in which the memory model accepts only every other cycle. To check the wrap points, the bench runs each channel for more requests than its list holds. For every element, it then compares the logged address sequence with the expected circular order, including an initial count of 1, where the loop completes on every element.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_READ  = 2'd1,
    MV_WRITE = 2'd2
  } mv_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/dma_req_arb.sv
module dma_req_arb #(
  parameter int unsigned NCH = 2,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           idle_i,
  output logic           gnt_o,
  output logic [CHW-1:0] gnt_ch_o,
  output logic [NCH-1:0] pend_o
);

  logic [NCH-1:0] pend_q, pend_d, clr;
  logic [CHW-1:0] sel;

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = CHW'(i);
    end
  end

  always_comb begin
    gnt_o = idle_i && (|pend_q);
    clr   = '0;
    if (gnt_o) clr[sel] = 1'b1;
    pend_d = (pend_q & ~clr) | req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign gnt_ch_o = sel;
  assign pend_o   = pend_q;

endmodule

// File: rtl/dma_desc.sv
module dma_desc #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [AW-1:0] cfg_src_i,
  input  logic [AW-1:0] cfg_dst_i,
  input  logic [AW-1:0] cfg_soff_i,
  input  logic [AW-1:0] cfg_doff_i,
  input  logic [AW-1:0] cfg_slast_i,
  input  logic [AW-1:0] cfg_dlast_i,
  input  logic [1:0]    cfg_size_i,
  input  logic [CW-1:0] cfg_iter_i,
  input  logic          adv_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [1:0]    size_o
);

  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [AW-1:0] soff_q, doff_q, slast_q, dlast_q;
  logic [1:0]    size_q;
  logic [CW-1:0] biter_q, citer_q, citer_d;
  logic          wrap;
  logic          upd_en;

  assign wrap   = (citer_q <= CW'(1));
  assign upd_en = ld_i || adv_i;

  always_comb begin
    src_d   = src_q;
    dst_d   = dst_q;
    citer_d = citer_q;
    if (ld_i) begin
      src_d   = cfg_src_i;
      dst_d   = cfg_dst_i;
      citer_d = cfg_iter_i;
    end else if (adv_i) begin
      src_d   = src_q + soff_q + (wrap ? slast_q : '0);
      dst_d   = dst_q + doff_q + (wrap ? dlast_q : '0);
      citer_d = wrap ? biter_q : citer_q - CW'(1);
    end
  end

  // static descriptor fields: enabled by load only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soff_q  <= '0;
      doff_q  <= '0;
      slast_q <= '0;
      dlast_q <= '0;
      size_q  <= '0;
      biter_q <= '0;
    end else if (ld_i) begin
      soff_q  <= cfg_soff_i;
      doff_q  <= cfg_doff_i;
      slast_q <= cfg_slast_i;
      dlast_q <= cfg_dlast_i;
      size_q  <= cfg_size_i;
      biter_q <= cfg_iter_i;
    end
  end

  // working state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      citer_q <= '0;
    end else if (upd_en) begin
      src_q   <= src_d;
      dst_q   <= dst_d;
      citer_q <= citer_d;
    end
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign size_o = size_q;

  AST_CITER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_i && citer_q == CW'(1)) |=> (citer_q == $past(biter_q))); // R5

  AST_CITER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_i && citer_q > CW'(1)) |=> (citer_q == $past(citer_q) - CW'(1))); // R5

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_ring_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned CHW = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gnt_i,
  input  logic [CHW-1:0] gnt_ch_i,
  input  logic [AW-1:0]  src_i,
  input  logic [AW-1:0]  dst_i,
  input  logic [1:0]     size_i,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_ready_i,
  output logic           idle_o,
  output logic [CHW-1:0] ch_o,
  output logic           done_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [1:0]     mem_size_o,
  output logic [DW-1:0]  mem_wdata_o
);

  mv_state_e      state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [DW-1:0]  data_q, data_d;
  logic [DW-1:0]  lane_mask;

  always_comb begin
    case (size_i)
      SZ_BYTE: lane_mask = {{(DW-8){1'b0}}, 8'hFF};
      SZ_HALF: lane_mask = {{(DW-16){1'b0}}, 16'hFFFF};
      default: lane_mask = {DW{1'b1}};
    endcase
  end

  always_comb begin
    state_d    = state_q;
    ch_d       = ch_q;
    data_d     = data_q;
    done_o     = 1'b0;
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = src_i;
    case (state_q)
      MV_IDLE: begin
        if (gnt_i) begin
          state_d = MV_READ;
          ch_d    = gnt_ch_i;
        end
      end
      MV_READ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src_i;
        if (mem_ready_i) begin
          data_d  = mem_rdata_i & lane_mask;
          state_d = MV_WRITE;
        end
      end
      MV_WRITE: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = dst_i;
        if (mem_ready_i) begin
          done_o  = 1'b1;
          state_d = MV_IDLE;
        end
      end
      default: state_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      ch_q    <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      data_q  <= data_d;
    end
  end

  assign idle_o      = (state_q == MV_IDLE);
  assign ch_o        = ch_q;
  assign mem_size_o  = size_i;
  assign mem_wdata_o = data_q;

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MV_READ && mem_ready_i) |=> (mem_req_o && mem_we_o)); // R2

  AST_WR_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_ready_i) |=> !mem_req_o); // R2

endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine #(
  parameter int unsigned NCH      = 2,
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned MAX_ITER = 8,
  localparam int unsigned CW      = $clog2(MAX_ITER + 1),
  localparam int unsigned CHW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          req_i,
  output logic [NCH-1:0]          ack_o,
  input  logic [NCH-1:0]          ld_i,
  input  logic [NCH-1:0][AW-1:0]  cfg_src_i,
  input  logic [NCH-1:0][AW-1:0]  cfg_dst_i,
  input  logic [NCH-1:0][AW-1:0]  cfg_soff_i,
  input  logic [NCH-1:0][AW-1:0]  cfg_doff_i,
  input  logic [NCH-1:0][AW-1:0]  cfg_slast_i,
  input  logic [NCH-1:0][AW-1:0]  cfg_dlast_i,
  input  logic [NCH-1:0][1:0]     cfg_size_i,
  input  logic [NCH-1:0][CW-1:0]  cfg_iter_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [1:0]              mem_size_o,
  output logic [DW-1:0]           mem_wdata_o,
  input  logic [DW-1:0]           mem_rdata_i,
  input  logic                    mem_ready_i
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic           mv_idle, mv_done, gnt;
  logic [CHW-1:0] gnt_ch, cur_ch;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] adv;
  logic [NCH-1:0] ack_q, ack_d;
  logic [NCH-1:0][AW-1:0] d_src, d_dst;
  logic [NCH-1:0][1:0]    d_size;
  logic [AW-1:0]  sel_src, sel_dst;
  logic [1:0]     sel_size;

  dma_req_arb #(.NCH(NCH)) u_arb (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .req_i    (req_i),
    .idle_i   (mv_idle),
    .gnt_o    (gnt),
    .gnt_ch_o (gnt_ch),
    .pend_o   (pend)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign adv[c] = mv_done && (cur_ch == CHW'(c));

    dma_desc #(.AW(AW), .CW(CW)) u_desc (
      .clk         (clk),
      .rst_n       (rst_s_n),
      .ld_i        (ld_i[c]),
      .cfg_src_i   (cfg_src_i[c]),
      .cfg_dst_i   (cfg_dst_i[c]),
      .cfg_soff_i  (cfg_soff_i[c]),
      .cfg_doff_i  (cfg_doff_i[c]),
      .cfg_slast_i (cfg_slast_i[c]),
      .cfg_dlast_i (cfg_dlast_i[c]),
      .cfg_size_i  (cfg_size_i[c]),
      .cfg_iter_i  (cfg_iter_i[c]),
      .adv_i       (adv[c]),
      .src_o       (d_src[c]),
      .dst_o       (d_dst[c]),
      .size_o      (d_size[c])
    );
  end

  always_comb begin
    sel_src  = d_src[0];
    sel_dst  = d_dst[0];
    sel_size = d_size[0];
    for (int c = 1; c < NCH; c++) begin
      if (cur_ch == CHW'(c)) begin
        sel_src  = d_src[c];
        sel_dst  = d_dst[c];
        sel_size = d_size[c];
      end
    end
  end

  dma_mover #(.AW(AW), .DW(DW), .CHW(CHW)) u_mover (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .gnt_i       (gnt),
    .gnt_ch_i    (gnt_ch),
    .src_i       (sel_src),
    .dst_i       (sel_dst),
    .size_i      (sel_size),
    .mem_rdata_i (mem_rdata_i),
    .mem_ready_i (mem_ready_i),
    .idle_o      (mv_idle),
    .ch_o        (cur_ch),
    .done_o      (mv_done),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_size_o  (mem_size_o),
    .mem_wdata_o (mem_wdata_o)
  );

  always_comb begin
    ack_d = '0;
    if (mv_done) ack_d[cur_ch] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ack_q <= '0;
    else          ack_q <= ack_d;
  end

  assign ack_o = ack_q;

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(ack_o)); // R2

  AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req_o && mem_we_o && mem_ready_i) |=> (ack_o != '0)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o))); // R9

  AST_PRIO_CH0: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req_o && !$past(mem_req_o) && cur_ch != '0) |-> !$past(pend[0])); // R6

endmodule

// File: tb/tb_dma_ring_engine.sv
`timescale 1ns/1ps
module tb_dma_ring_engine;

  localparam int NCH = 2;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int CW  = 4;
  localparam logic [31:0] PUSH = 32'h0000_8000;
  localparam logic [31:0] POP  = 32'h0000_C000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NCH-1:0]         req = '0;
  logic [NCH-1:0]         ack;
  logic [NCH-1:0]         ld = '0;
  logic [NCH-1:0][AW-1:0] c_src = '0, c_dst = '0, c_soff = '0, c_doff = '0;
  logic [NCH-1:0][AW-1:0] c_slast = '0, c_dlast = '0;
  logic [NCH-1:0][1:0]    c_size = '0;
  logic [NCH-1:0][CW-1:0] c_iter = '0;
  logic                   mem_req, mem_we, mem_ready;
  logic [AW-1:0]          mem_addr;
  logic [1:0]             mem_size;
  logic [DW-1:0]          mem_wdata, mem_rdata;

  dma_ring_engine dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ack_o(ack), .ld_i(ld),
    .cfg_src_i(c_src), .cfg_dst_i(c_dst), .cfg_soff_i(c_soff), .cfg_doff_i(c_doff),
    .cfg_slast_i(c_slast), .cfg_dlast_i(c_dlast), .cfg_size_i(c_size), .cfg_iter_i(c_iter),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
  );

  // memory model
  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'd3) ^ 32'hC0DE_0000;
  endfunction

  logic        stall_en = 1'b0;
  logic        phase = 1'b0;
  logic [15:0] pop_cnt = '0;
  assign mem_ready = !stall_en || phase;
  assign mem_rdata = (mem_addr == POP) ? (32'h5A5A_0000 | {16'h0, pop_cnt}) : pat(mem_addr);

  // access log and monitors
  logic [31:0] lg_addr [0:127];
  logic [31:0] lg_data [0:127];
  logic        lg_we   [0:127];
  logic [1:0]  lg_size [0:127];
  int          lg_n = 0;
  int          ack_cnt [0:1] = '{0, 0};
  int          stall_err = 0;
  logic        prev_stalled = 1'b0;
  logic [31:0] prev_addr = '0;

  always @(posedge clk) begin
    phase <= ~phase;
    if (mem_req && mem_ready && lg_n < 128) begin
      lg_addr[lg_n] <= mem_addr;
      lg_data[lg_n] <= mem_we ? mem_wdata : mem_rdata;
      lg_we[lg_n]   <= mem_we;
      lg_size[lg_n] <= mem_size;
      lg_n          <= lg_n + 1;
      if (!mem_we && mem_addr == POP) pop_cnt <= pop_cnt + 16'd1;
    end
    if (prev_stalled && (!mem_req || mem_addr != prev_addr)) stall_err <= stall_err + 1;
    prev_stalled <= mem_req && !mem_ready;
    prev_addr    <= mem_addr;
    if (ack[0]) ack_cnt[0] <= ack_cnt[0] + 1;
    if (ack[1]) ack_cnt[1] <= ack_cnt[1] + 1;
  end

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  task automatic load(input int ch, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] so, input logic [31:0] doo,
                      input logic [31:0] sl, input logic [31:0] dl,
                      input logic [1:0] sz, input logic [3:0] it);
    @(negedge clk);
    c_src[ch] = s; c_dst[ch] = d; c_soff[ch] = so; c_doff[ch] = doo;
    c_slast[ch] = sl; c_dlast[ch] = dl; c_size[ch] = sz; c_iter[ch] = it;
    ld[ch] = 1'b1;
    @(negedge clk);
    ld[ch] = 1'b0;
  endtask

  task automatic wait_ack(input int ch, input int target);
    for (int k = 0; k < 300; k++) begin
      if (ack_cnt[ch] >= target) break;
      @(negedge clk);
    end
    check(ack_cnt[ch] >= target, "R2 ack count", ack_cnt[ch], target);
  endtask

  task automatic one_req(input int ch);
    int tgt;
    tgt = ack_cnt[ch] + 1;
    @(negedge clk);
    req[ch] = 1'b1;
    @(negedge clk);
    req[ch] = 1'b0;
    wait_ack(ch, tgt);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(mem_req == 1'b0, "R1 mem_req idle", mem_req, 0);
      check(ack == '0, "R1 ack idle", ack, 0);
    end
  endtask

  task automatic t_cmd_loop;
    int b;
    logic [31:0] ra;
    load(0, 32'h100, PUSH, 32'd4, 32'd0, 32'hFFFF_FFF0, 32'd0, 2'd2, 4'd4);
    b = lg_n;
    for (int k = 0; k < 6; k++) one_req(0);
    check(lg_n - b == 12, "R2 access count cmd", lg_n - b, 12);
    for (int k = 0; k < 6; k++) begin
      ra = 32'h100 + 32'(4 * (k % 4));
      check(lg_we[b+2*k] == 1'b0 && lg_we[b+2*k+1] == 1'b1, "R2 read then write",
            {lg_we[b+2*k], lg_we[b+2*k+1]}, 32'b01);
      check(lg_addr[b+2*k] == ra, "R5 R4 cmd source wrap", lg_addr[b+2*k], ra);
      check(lg_addr[b+2*k+1] == PUSH, "R4 fixed push dest", lg_addr[b+2*k+1], PUSH);
      check(lg_data[b+2*k+1] == pat(ra), "R3 cmd data", lg_data[b+2*k+1], pat(ra));
      check(lg_size[b+2*k+1] == 2'd2, "R3 word size", lg_size[b+2*k+1], 2);
    end
  endtask

  task automatic t_res_loop;
    int b;
    logic [15:0] p0;
    logic [31:0] wa;
    load(1, POP, 32'h200, 32'd0, 32'd2, 32'd0, 32'hFFFF_FFFA, 2'd1, 4'd3);
    p0 = pop_cnt;
    b = lg_n;
    for (int k = 0; k < 4; k++) one_req(1);
    check(lg_n - b == 8, "R2 access count res", lg_n - b, 8);
    for (int k = 0; k < 4; k++) begin
      wa = 32'h200 + 32'(2 * (k % 3));
      check(lg_addr[b+2*k] == POP, "R4 fixed pop source", lg_addr[b+2*k], POP);
      check(lg_addr[b+2*k+1] == wa, "R5 R4 res dest wrap", lg_addr[b+2*k+1], wa);
      check(lg_data[b+2*k+1] == {16'h0, p0 + 16'(k)}, "R3 half masked data",
            lg_data[b+2*k+1], {16'h0, p0 + 16'(k)});
      check(lg_size[b+2*k] == 2'd1, "R3 half size", lg_size[b+2*k], 1);
    end
  endtask

  task automatic t_prio;
    int b, t0, t1;
    load(0, 32'h100, PUSH, 32'd4, 32'd0, 32'hFFFF_FFF0, 32'd0, 2'd2, 4'd4);
    b = lg_n; t0 = ack_cnt[0] + 1; t1 = ack_cnt[1] + 1;
    @(negedge clk);
    req = 2'b11;
    @(negedge clk);
    req = 2'b00;
    wait_ack(0, t0);
    wait_ack(1, t1);
    repeat (2) @(negedge clk);
    check(lg_addr[b] == 32'h100, "R6 channel 0 first", lg_addr[b], 32'h100);
    check(lg_addr[b+2] == POP, "R6 channel 1 second", lg_addr[b+2], POP);
  endtask

  task automatic t_held;
    int b, tg;
    load(0, 32'h100, PUSH, 32'd4, 32'd0, 32'hFFFF_FFF0, 32'd0, 2'd2, 4'd4);
    b = lg_n; tg = ack_cnt[0] + 2;
    stall_en = 1'b1;
    @(negedge clk);
    req[0] = 1'b1;
    @(negedge clk);
    req[0] = 1'b0;
    for (int k = 0; k < 20 && !mem_req; k++) @(negedge clk);
    req[0] = 1'b1;
    @(negedge clk);
    req[0] = 1'b0;
    wait_ack(0, tg);
    stall_en = 1'b0;
    repeat (2) @(negedge clk);
    check(lg_n - b == 4, "R7 held request served", lg_n - b, 4);
    check(lg_addr[b+2] == 32'h104, "R7 second element", lg_addr[b+2], 32'h104);
  endtask

  task automatic t_stall;
    int b;
    b = lg_n;
    stall_en = 1'b1;
    one_req(1);
    stall_en = 1'b0;
    check(lg_n - b == 2, "R9 one read one write under stall", lg_n - b, 2);
    check(stall_err == 0, "R9 access held while stalled", stall_err, 0);
    check(lg_data[b+1] == {16'h0, lg_data[b][15:0]}, "R9 data under stall",
          lg_data[b+1], {16'h0, lg_data[b][15:0]});
  endtask

  task automatic t_cfg_ignored;
    int b;
    load(0, 32'h100, PUSH, 32'd4, 32'd0, 32'hFFFF_FFF0, 32'd0, 2'd2, 4'd4);
    @(negedge clk);
    c_src[0] = 32'h900; c_dst[0] = 32'h700; c_size[0] = 2'd0;
    b = lg_n;
    one_req(0);
    check(lg_addr[b] == 32'h100, "R8 source unchanged without load", lg_addr[b], 32'h100);
    check(lg_addr[b+1] == PUSH, "R8 dest unchanged without load", lg_addr[b+1], PUSH);
    check(lg_size[b] == 2'd2, "R8 size unchanged without load", lg_size[b], 2);
  endtask

  task automatic t_iter1;
    int b;
    load(0, 32'h300, PUSH, 32'd4, 32'd0, 32'hFFFF_FFFC, 32'd0, 2'd2, 4'd1);
    b = lg_n;
    for (int k = 0; k < 3; k++) one_req(0);
    for (int k = 0; k < 3; k++)
      check(lg_addr[b+2*k] == 32'h300, "R10 count of one rereads", lg_addr[b+2*k], 32'h300);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cmd_loop();
    t_res_loop();
    t_prio();
    t_held();
    t_stall();
    t_cfg_ignored();
    t_iter1();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule